// File: doc/BRIEF.md
# Register Port Selection and Operand Forwarding Control

This block steers the register-file port numbers of a three-stage 16-bit pipeline (fetch, decode, execute) that has sixteen general registers. The register file is time-multiplexed. In the high half of each clock the two port numbers name the source registers of the instruction in decode. In the low half both name the destination of the instruction in execute, so that its result can be written back. The block also keeps a small record of the execute-stage instruction: its destination, whether it writes at all, and whether it is an immediate-prefix word. From that record it derives a forward-into-A select, a writeback enable and the clock enables for the B operand register.

An external decoder reduces the decode-stage opcode to a 3-bit class. The block takes that class together with the raw rd, ra and rb fields. A separate annul machine reports whether the current execute-stage instruction is annulled. Only operand A has a forwarding path. A dependency through operand B must be removed by software, either by swapping the operands or by padding with nops.

All pins are plain control levels. No data stream crosses this boundary, so there is no valid/ready handshake and no back-pressure. The pipeline enable is the only stall mechanism.

Top module: `regport_fwd_ctl`

## Requirements
- R1: With `phase_hi` = 1, `port_a` gives the decode-stage source A, chosen by class:
  - `rd` for class 0 (register/register and register/immediate formats) and for class 7 (immediate prefix);
  - `ra` for class 1 (add/sub), class 2 (add immediate), class 3 (load), class 4 (store) and class 5 (jump-and-link);
  - register 0 for class 6 (call).
- R2: With `phase_hi` = 1, `port_b` gives `rd` for class 4 (store) and `rb` for every other class.
- R3: With `phase_hi` = 0, `port_a` and `port_b` both give the execute-stage destination. That destination is the `rd` captured at the last enabled clock edge, or register 15 if the captured instruction was class 6 (call).
- R4: `fwd_a` is 1 exactly when all four of these hold:
  - the execute-stage instruction writes;
  - `ex_annul` = 0;
  - its destination is not register 0;
  - its destination equals the decode-stage source A of R1.
- R5: A match between the execute-stage destination and the decode-stage B source never asserts `fwd_a`.
- R6: `b_lo_ce` equals `pipe_en`. `b_hi_ce` equals `pipe_en` except when the execute-stage instruction is class 7, in which case it is 0.
- R7: While `pipe_en` = 0, the execute-stage record (destination, write flag, prefix flag) holds its value.
- R8: `wb_en` is 1 exactly when the execute-stage instruction writes, is not annulled and has a destination other than register 0. Classes 4 and 7 never write.
- R9: While `rst_n` = 0 (asynchronous, active low), the execute-stage record is cleared to destination 0, no write and no prefix. Hence `wb_en` = 0 and `fwd_a` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pipeline clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pipe_en | input | 1 | Pipeline advance enable |
| phase_hi | input | 1 | 1 during the high half of the clock (read phase) |
| dc_class | input | 3 | Decoded class of the decode-stage instruction |
| dc_rd | input | 4 | Decode-stage rd field |
| dc_ra | input | 4 | Decode-stage ra field |
| dc_rb | input | 4 | Decode-stage rb field |
| ex_annul | input | 1 | Execute-stage instruction is annulled |
| port_a | output | 4 | Register-file port A number |
| port_b | output | 4 | Register-file port B number |
| fwd_a | output | 1 | Select the execute result into operand A |
| wb_en | output | 1 | Writeback enable for the execute-stage result |
| b_lo_ce | output | 1 | Clock enable for B operand bits 3:0 |
| b_hi_ce | output | 1 | Clock enable for B operand bits 15:4 |

## Verification
The hardest situations to reach are those where a port value or the forward select depends on an execute-stage record captured several cycles earlier. Examples are a low-phase port value frozen by a stall, and a forward match that must be suppressed because the earlier instruction was a store, an annulled instruction or a write to register 0. The vector table is ordered so that each entry sets up the execute-stage record that the next entry probes. Some entries keep `pipe_en` low on purpose, which carries one record across several probes. A call is placed just before a low-phase entry so that the implicit register 15 destination becomes visible on the ports.

// File: rtl/rps_pkg.sv
package rps_pkg;

  typedef enum logic [2:0] {
    CLS_RRRI   = 3'd0,
    CLS_ADDSUB = 3'd1,
    CLS_ADDI   = 3'd2,
    CLS_LOAD   = 3'd3,
    CLS_STORE  = 3'd4,
    CLS_JAL    = 3'd5,
    CLS_CALL   = 3'd6,
    CLS_IMMPFX = 3'd7
  } cls_e;

  typedef enum logic [1:0] {
    SRC_RA   = 2'd0,
    SRC_RD   = 2'd1,
    SRC_ZERO = 2'd2
  } src_a_e;

  typedef struct packed {
    src_a_e a_src;
    logic   b_from_rd;
    logic   writes;
    logic   is_call;
    logic   is_imm;
  } dec_t;

endpackage

// File: rtl/rps_class_decode.sv
module rps_class_decode
  import rps_pkg::*;
(
  input  cls_e cls,
  output dec_t dec
);

  always_comb begin
    dec           = '0;
    dec.a_src     = SRC_RA;
    dec.b_from_rd = 1'b0;
    dec.writes    = 1'b1;
    dec.is_call   = 1'b0;
    dec.is_imm    = 1'b0;
    unique case (cls)
      CLS_RRRI:   dec.a_src = SRC_RD;
      CLS_ADDSUB,
      CLS_ADDI,
      CLS_LOAD,
      CLS_JAL:    dec.a_src = SRC_RA;
      CLS_STORE: begin
        dec.a_src     = SRC_RA;
        dec.b_from_rd = 1'b1;
        dec.writes    = 1'b0;
      end
      CLS_CALL: begin
        dec.a_src   = SRC_ZERO;
        dec.is_call = 1'b1;
      end
      CLS_IMMPFX: begin
        dec.a_src  = SRC_RD;
        dec.writes = 1'b0;
        dec.is_imm = 1'b1;
      end
      default: dec.a_src = SRC_RA;
    endcase
  end

endmodule

// File: rtl/rps_ex_track.sv
module rps_ex_track #(
  parameter int unsigned AW       = 4,
  parameter int unsigned LINK_REG = 15
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pipe_en,
  input  logic [AW-1:0] dc_rd,
  input  logic          dc_writes,
  input  logic          dc_is_call,
  input  logic          dc_is_imm,
  output logic [AW-1:0] ex_dest,
  output logic          ex_wr,
  output logic          ex_imm
);

  localparam logic [AW-1:0] LINK = AW'(LINK_REG);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ex_dest <= '0;
      ex_wr   <= 1'b0;
      ex_imm  <= 1'b0;
    end else if (pipe_en) begin
      ex_dest <= dc_is_call ? LINK : dc_rd;
      ex_wr   <= dc_writes;
      ex_imm  <= dc_is_imm;
    end
  end

  // R7
  ex_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pipe_en |=> ($stable(ex_dest) && $stable(ex_wr) && $stable(ex_imm)));

  // R3
  call_link_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pipe_en && dc_is_call) |=> (ex_dest == LINK));

endmodule

// File: rtl/rps_port_mux.sv
module rps_port_mux
  import rps_pkg::*;
#(
  parameter int unsigned AW = 4
) (
  input  logic          phase_hi,
  input  src_a_e        a_src,
  input  logic          b_from_rd,
  input  logic [AW-1:0] dc_rd,
  input  logic [AW-1:0] dc_ra,
  input  logic [AW-1:0] dc_rb,
  input  logic [AW-1:0] ex_dest,
  output logic [AW-1:0] dc_src_a,
  output logic [AW-1:0] port_a,
  output logic [AW-1:0] port_b
);

  logic [AW-1:0] dc_src_b;

  always_comb begin
    unique case (a_src)
      SRC_RD:   dc_src_a = dc_rd;
      SRC_ZERO: dc_src_a = '0;
      default:  dc_src_a = dc_ra;
    endcase
  end

  assign dc_src_b = b_from_rd ? dc_rd : dc_rb;
  assign port_a   = phase_hi ? dc_src_a : ex_dest;
  assign port_b   = phase_hi ? dc_src_b : ex_dest;

endmodule

// File: rtl/rps_fwd_ctl.sv
module rps_fwd_ctl #(
  parameter int unsigned AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pipe_en,
  input  logic [AW-1:0] ex_dest,
  input  logic          ex_wr,
  input  logic          ex_imm,
  input  logic          ex_annul,
  input  logic [AW-1:0] dc_src_a,
  output logic          fwd_a,
  output logic          wb_en,
  output logic          b_lo_ce,
  output logic          b_hi_ce
);

  logic retire;

  assign retire  = ex_wr && !ex_annul && (ex_dest != '0);
  assign wb_en   = retire;
  assign fwd_a   = retire && (ex_dest == dc_src_a);
  assign b_lo_ce = pipe_en;
  assign b_hi_ce = pipe_en && !ex_imm;

  // R4
  fwd_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_a |-> (!ex_annul && ex_dest != '0 && ex_dest == dc_src_a));

  // R8
  wb_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |-> (ex_dest != '0 && !ex_annul));

  // R6
  bce_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    b_hi_ce |-> b_lo_ce);

  // R6
  prefix_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ex_imm |-> !b_hi_ce);

endmodule

// File: rtl/regport_fwd_ctl.sv
module regport_fwd_ctl
  import rps_pkg::*;
#(
  parameter int unsigned NREGS    = 16,
  parameter int unsigned LINK_REG = 15,
  localparam int unsigned AW      = $clog2(NREGS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pipe_en,
  input  logic          phase_hi,
  input  logic [2:0]    dc_class,
  input  logic [AW-1:0] dc_rd,
  input  logic [AW-1:0] dc_ra,
  input  logic [AW-1:0] dc_rb,
  input  logic          ex_annul,
  output logic [AW-1:0] port_a,
  output logic [AW-1:0] port_b,
  output logic          fwd_a,
  output logic          wb_en,
  output logic          b_lo_ce,
  output logic          b_hi_ce
);

  dec_t          dec;
  logic [AW-1:0] ex_dest;
  logic          ex_wr;
  logic          ex_imm;
  logic [AW-1:0] dc_src_a;

  rps_class_decode u_dec (
    .cls (cls_e'(dc_class)),
    .dec (dec)
  );

  rps_ex_track #(.AW(AW), .LINK_REG(LINK_REG)) u_ex (
    .clk        (clk),
    .rst_n      (rst_n),
    .pipe_en    (pipe_en),
    .dc_rd      (dc_rd),
    .dc_writes  (dec.writes),
    .dc_is_call (dec.is_call),
    .dc_is_imm  (dec.is_imm),
    .ex_dest    (ex_dest),
    .ex_wr      (ex_wr),
    .ex_imm     (ex_imm)
  );

  rps_port_mux #(.AW(AW)) u_mux (
    .phase_hi  (phase_hi),
    .a_src     (dec.a_src),
    .b_from_rd (dec.b_from_rd),
    .dc_rd     (dc_rd),
    .dc_ra     (dc_ra),
    .dc_rb     (dc_rb),
    .ex_dest   (ex_dest),
    .dc_src_a  (dc_src_a),
    .port_a    (port_a),
    .port_b    (port_b)
  );

  rps_fwd_ctl #(.AW(AW)) u_fwd (
    .clk      (clk),
    .rst_n    (rst_n),
    .pipe_en  (pipe_en),
    .ex_dest  (ex_dest),
    .ex_wr    (ex_wr),
    .ex_imm   (ex_imm),
    .ex_annul (ex_annul),
    .dc_src_a (dc_src_a),
    .fwd_a    (fwd_a),
    .wb_en    (wb_en),
    .b_lo_ce  (b_lo_ce),
    .b_hi_ce  (b_hi_ce)
  );

  // R9
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |-> (!wb_en && !fwd_a));

endmodule

// File: tb/regport_fwd_ctl_tb.sv
`timescale 1ns/1ps
module regport_fwd_ctl_tb;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       pipe_en, phase_hi, ex_annul;
  logic [2:0] dc_class;
  logic [3:0] dc_rd, dc_ra, dc_rb;
  logic [3:0] port_a, port_b;
  logic       fwd_a, wb_en, b_lo_ce, b_hi_ce;

  int n_run  = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  regport_fwd_ctl u_dut (
    .clk(clk), .rst_n(rst_n), .pipe_en(pipe_en), .phase_hi(phase_hi),
    .dc_class(dc_class), .dc_rd(dc_rd), .dc_ra(dc_ra), .dc_rb(dc_rb),
    .ex_annul(ex_annul), .port_a(port_a), .port_b(port_b), .fwd_a(fwd_a),
    .wb_en(wb_en), .b_lo_ce(b_lo_ce), .b_hi_ce(b_hi_ce)
  );

  function automatic logic [28:0] vec(
    input int cls, input int rd, input int ra, input int rb,
    input int ph, input int en, input int an,
    input int ea, input int eb, input int ef, input int ew, input int eh);
    return {3'(cls), 4'(rd), 4'(ra), 4'(rb), 1'(ph), 1'(en), 1'(an),
            4'(ea), 4'(eb), 1'(ef), 1'(ew), 1'(eh)};
  endfunction

  localparam int NV = 13;
  // cls rd ra rb ph en an | expA expB fwd wb bhi
  localparam logic [28:0] VT [0:NV-1] = '{
    vec(0, 3, 5, 7, 1, 1, 0,  3,  7, 0, 0, 1), // R1 rd source; empty EX
    vec(1, 4, 3, 2, 1, 1, 0,  3,  2, 1, 1, 1), // R4 forward ra=3
    vec(4, 4, 9, 1, 1, 1, 0,  9,  4, 0, 1, 1), // R2 store B=rd, R5 no B fwd
    vec(0, 4, 0, 0, 1, 1, 0,  4,  0, 0, 0, 1), // R4/R8 store does not write
    vec(6, 8, 4, 4, 0, 1, 0,  4,  4, 0, 1, 1), // R3 low phase, R1 call reads r0
    vec(7,15, 1, 2, 0, 1, 1, 15, 15, 0, 0, 1), // R3 call dest r15, R8 annul
    vec(2, 0, 6, 3, 1, 1, 0,  6,  3, 0, 0, 0), // R6 prefix blocks upper ce
    vec(3, 2, 0, 5, 1, 1, 0,  0,  5, 0, 0, 1), // R4/R8 dest r0 no fwd
    vec(5, 1, 2, 2, 1, 0, 0,  2,  2, 1, 1, 0), // R4 jal ra fwd; stall
    vec(6, 7, 7, 7, 0, 0, 0,  2,  2, 0, 1, 0), // R7 held dest under stall
    vec(0, 2, 0, 0, 1, 0, 1,  2,  0, 0, 0, 0), // R4 annul blocks fwd
    vec(5, 0, 2,11, 1, 1, 0,  2, 11, 1, 1, 1), // R1 jal ra
    vec(1, 5, 0, 0, 0, 1, 0,  0,  0, 0, 0, 1)  // R8 jal into r0 no write
  };

  task automatic chk(input string tag, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  initial begin
    #2000000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; pipe_en = 1'b0; phase_hi = 1'b0; ex_annul = 1'b0;
    dc_class = '0; dc_rd = '0; dc_ra = '0; dc_rb = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); #1;
    chk("R9 reset port_a", port_a, 0);
    chk("R9 reset wb_en", wb_en, 0);
    chk("R9 reset fwd_a", fwd_a, 0);
    chk("R6 reset b_hi_ce", b_hi_ce, 0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      dc_class = VT[i][28:26]; dc_rd = VT[i][25:22];
      dc_ra = VT[i][21:18]; dc_rb = VT[i][17:14];
      phase_hi = VT[i][13]; pipe_en = VT[i][12]; ex_annul = VT[i][11];
      #1;
      chk($sformatf("R1/R3 port_a v%0d", i), port_a, VT[i][10:7]);
      chk($sformatf("R2/R3/R7 port_b v%0d", i), port_b, VT[i][6:3]);
      chk($sformatf("R4/R5 fwd_a v%0d", i), fwd_a, VT[i][2]);
      chk($sformatf("R8 wb_en v%0d", i), wb_en, VT[i][1]);
      chk($sformatf("R6 b_hi_ce v%0d", i), b_hi_ce, VT[i][0]);
      chk($sformatf("R6 b_lo_ce v%0d", i), b_lo_ce, VT[i][12]);
    end

    // R9: reset asserted mid-run clears the execute record at once
    @(negedge clk);
    dc_class = 3'd1; dc_rd = 4'd9; dc_ra = 4'd0; dc_rb = 4'd0;
    phase_hi = 1'b0; pipe_en = 1'b1; ex_annul = 1'b0;
    rst_n = 1'b0;
    #1;
    chk("R9 mid reset port_a", port_a, 0);
    chk("R9 mid reset wb_en", wb_en, 0);
    chk("R9 mid reset b_hi_ce", b_hi_ce, 1);
    phase_hi = 1'b1;
    #1;
    chk("R9 mid reset fwd_a", fwd_a, 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule